// File: doc/BRIEF.md
# PCI Slot Interrupt Router with Edge/Level Delivery

This block takes interrupt activity from the four interrupt pins of a PCI slot and folds it onto a bank of 32 internal interrupt lines. The internal lines carry the numbers 32 to 63. A fixed routing rule picks the line from the slot number and the pin index. The integrated peripheral slot passes its pins straight onto the first four lines. Two dedicated device slots each own a single line. The add-in slots rotate their pins across a shared group of lines, so that pin A of neighbouring slots lands on different lines.

Each internal line has a bit in an edge mask and a bit in a polarity mask, both indexed by the line number minus 32. The upstream interrupt output depends on the edge bit. When the edge bit is set, a rising pin level sends out a single-clock pulse. When the edge bit is clear, any change of pin level drives the output to the line's polarity bit, and the output holds that value until the next event. A slot outside the routing rule gets no internal line, and its pin activity has no effect on the output. A per-line record of the last level seen decides whether a given cycle carries an event.

Top module: `pci_irq_router`

## Requirements
- R1: Slot 5 with pin index p (0 to 3) reports line number 32 + (p mod 4).
- R2: Slot 6 reports line 36 and slot 7 reports line 37, whatever the pin index.
- R3: Slots 8 to 12 with pin index p report line 32 + 6 + (slot - 8) + p, which is always in the range 38 to 45.
- R4: Any other slot reports the pin index itself (0 to 3) as the line number, and pin level changes on it leave irqOut unchanged.
- R5: Reset, asynchronous and active low, drives irqOut to 0 and clears every line's level record to 0.
- R6: A 0-to-1 change of the pin level on a line whose edgeMask bit (index = line - 32) is 1 makes irqOut 1 after the clock edge that samples it. irqOut returns to 0 one edge later, unless a new event arrives in that cycle.
- R7: On a line in edge mode, a falling pin level or a steady level does not start a pulse.
- R8: On a line whose edgeMask bit is 0, a change of pin level in either direction sets irqOut to that line's polMask bit after the sampling clock edge.
- R9: While no event occurs and no pulse is active, irqOut holds its value, even when polMask or edgeMask change.
- R10: When a level-mode event falls in the last cycle of a pulse, the level-mode value wins, so a polMask bit of 1 keeps irqOut at 1.
- R11: An event is a pin level that differs from the last level recorded for the same line. Moving between lines creates no event on a line whose recorded level matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotNum | input | 5 | Slot presenting activity this cycle |
| pinIdx | input | 2 | Interrupt pin of that slot (0 = A to 3 = D) |
| pinLevel | input | 1 | Current level of that pin |
| edgeMask | input | 32 | Per internal line: 1 = pulse delivery, 0 = level delivery |
| polMask | input | 32 | Per internal line: value driven on a level-mode event |
| lineNum | output | 6 | Mapped line number (combinational) |
| irqOut | output | 1 | Upstream interrupt |

## Verification
Two functions can land in the same cycle. The expiry of a one-cycle edge pulse can coincide with a level-mode event on a different line. The bench provokes this by raising an edge-mode pin and, on the very next cycle, toggling a level-mode pin whose polarity bit is 1. It then judges that irqOut stays at 1 rather than dropping, and that it keeps holding on the cycle after. The opposite case is also run: the pulse is followed only by activity on an unmapped slot, and irqOut is expected to fall back to 0.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic capture;   // record the present pin level for the mapped line
    logic drvHigh;   // drive the upstream output to 1
    logic drvLow;    // drive the upstream output to 0
  } pirqCtrl_t;

  // Event information returned by the datapath
  typedef struct packed {
    logic lineValid; // slot/pin reached an internal line
    logic evt;       // pin level differs from the recorded level
    logic levelNow;  // present pin level
    logic edgeMode;  // edge-mask bit of the mapped line
    logic polBit;    // polarity-mask bit of the mapped line
  } pirqStat_t;

endpackage

// File: rtl/pirq_slot_map.sv
`timescale 1ns/1ps
module pirq_slot_map #(
  parameter int SLOT_W      = 5,
  parameter int PIN_W       = 2,
  parameter int NUM_LINES   = 32,
  parameter int LINE_BASE   = 32,
  parameter int LINE_W      = 6,
  parameter int IDX_W       = 5,
  parameter int PINS        = 4,
  parameter int SOUTH_SLOT  = 5,
  parameter int VIDEO_SLOT  = 6,
  parameter int VIDEO_LINE  = 4,
  parameter int NET_SLOT    = 7,
  parameter int NET_LINE    = 5,
  parameter int ADDIN_FIRST = 8,
  parameter int ADDIN_LAST  = 12,
  parameter int ADDIN_LINE  = 6
) (
  input  logic [SLOT_W-1:0] slotNum,
  input  logic [PIN_W-1:0]  pinIdx,
  output logic              lineValid,
  output logic [IDX_W-1:0]  lineIdx,
  output logic [LINE_W-1:0] lineNum
);

  logic [LINE_W-1:0] offs;
  logic [LINE_W-1:0] pinWide;
  logic [LINE_W-1:0] slotWide;

  assign pinWide  = LINE_W'(pinIdx);
  assign slotWide = LINE_W'(slotNum);

  always_comb begin
    lineValid = 1'b1;
    offs      = '0;
    if (slotNum == SLOT_W'(SOUTH_SLOT)) begin
      offs = pinWide % LINE_W'(PINS);
    end else if (slotNum == SLOT_W'(VIDEO_SLOT)) begin
      offs = LINE_W'(VIDEO_LINE);
    end else if (slotNum == SLOT_W'(NET_SLOT)) begin
      offs = LINE_W'(NET_LINE);
    end else if (slotNum >= SLOT_W'(ADDIN_FIRST) && slotNum <= SLOT_W'(ADDIN_LAST)) begin
      offs = slotWide - LINE_W'(ADDIN_FIRST) + pinWide + LINE_W'(ADDIN_LINE);
    end else begin
      lineValid = 1'b0;
    end
  end

  assign lineIdx = offs[IDX_W-1:0];
  assign lineNum = lineValid ? (LINE_W'(LINE_BASE) + offs) : pinWide;

endmodule

// File: rtl/pirq_datapath.sv
`timescale 1ns/1ps
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int NUM_LINES = 32,
  parameter int LINE_BASE = 32,
  parameter int LINE_W    = 6,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SLOT_W-1:0]    slotNum,
  input  logic [PIN_W-1:0]     pinIdx,
  input  logic                 pinLevel,
  input  logic [NUM_LINES-1:0] edgeMask,
  input  logic [NUM_LINES-1:0] polMask,
  input  pirqCtrl_t            ctrl,
  output pirqStat_t            stat,
  output logic [LINE_W-1:0]    lineNum,
  output logic                 irqOut
);

  logic             lineValid;
  logic [IDX_W-1:0] lineIdx;
  logic             levelSeen [NUM_LINES];

  pirq_slot_map #(
    .SLOT_W   (SLOT_W),
    .PIN_W    (PIN_W),
    .NUM_LINES(NUM_LINES),
    .LINE_BASE(LINE_BASE),
    .LINE_W   (LINE_W),
    .IDX_W    (IDX_W)
  ) i_map (
    .slotNum  (slotNum),
    .pinIdx   (pinIdx),
    .lineValid(lineValid),
    .lineIdx  (lineIdx),
    .lineNum  (lineNum)
  );

  // One level record per internal line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_levelRec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        levelSeen[g] <= 1'b0;
      end else if (ctrl.capture && lineIdx == IDX_W'(g)) begin
        levelSeen[g] <= pinLevel;
      end
    end
  end

  always_comb begin
    stat.lineValid = lineValid;
    stat.evt       = lineValid && (pinLevel != levelSeen[lineIdx]);
    stat.levelNow  = pinLevel;
    stat.edgeMode  = edgeMask[lineIdx];
    stat.polBit    = polMask[lineIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else if (ctrl.drvHigh) begin
      irqOut <= 1'b1;
    end else if (ctrl.drvLow) begin
      irqOut <= 1'b0;
    end
  end

endmodule

// File: rtl/pirq_control.sv
`timescale 1ns/1ps
module pirq_control
  import pirq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pirqStat_t stat,
  output pirqCtrl_t ctrl,
  output logic      pulseActive
);

  logic pulseNext;

  always_comb begin
    ctrl.capture = stat.lineValid;
    ctrl.drvHigh = 1'b0;
    ctrl.drvLow  = 1'b0;
    pulseNext    = 1'b0;
    if (stat.evt && !stat.edgeMode) begin
      // level delivery: output follows the polarity bit
      ctrl.drvHigh = stat.polBit;
      ctrl.drvLow  = !stat.polBit;
    end else if (stat.evt && stat.levelNow) begin
      // edge delivery on a rising level: start a one-clock pulse
      ctrl.drvHigh = 1'b1;
      pulseNext    = 1'b1;
    end else if (pulseActive) begin
      ctrl.drvLow  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
    end else begin
      pulseActive <= pulseNext;
    end
  end

endmodule

// File: rtl/pci_irq_router.sv
`timescale 1ns/1ps
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int NUM_LINES = 32,
  parameter int LINE_BASE = 32,
  localparam int LINE_W   = $clog2(LINE_BASE + NUM_LINES),
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SLOT_W-1:0]    slotNum,
  input  logic [PIN_W-1:0]     pinIdx,
  input  logic                 pinLevel,
  input  logic [NUM_LINES-1:0] edgeMask,
  input  logic [NUM_LINES-1:0] polMask,
  output logic [LINE_W-1:0]    lineNum,
  output logic                 irqOut
);

  pirqCtrl_t ctrl;
  pirqStat_t stat;
  logic      pulseActive;

  pirq_datapath #(
    .SLOT_W   (SLOT_W),
    .PIN_W    (PIN_W),
    .NUM_LINES(NUM_LINES),
    .LINE_BASE(LINE_BASE),
    .LINE_W   (LINE_W),
    .IDX_W    (IDX_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .slotNum (slotNum),
    .pinIdx  (pinIdx),
    .pinLevel(pinLevel),
    .edgeMask(edgeMask),
    .polMask (polMask),
    .ctrl    (ctrl),
    .stat    (stat),
    .lineNum (lineNum),
    .irqOut  (irqOut)
  );

  pirq_control i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (stat),
    .ctrl       (ctrl),
    .pulseActive(pulseActive)
  );

endmodule

// File: rtl/pirq_checker.sv
`timescale 1ns/1ps
module pirq_checker #(
  parameter int LINE_W    = 6,
  parameter int LINE_BASE = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineValid,
  input logic [LINE_W-1:0] lineNum,
  input logic              evt,
  input logic              edgeMode,
  input logic              polBit,
  input logic              pinLevel,
  input logic              pulseActive,
  input logic              irqOut
);

  p_mapped_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> (lineNum >= LINE_W'(LINE_BASE)));

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evt && edgeMode && pinLevel) |=> irqOut);

  p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !evt) |=> !irqOut);

  p_level_pol_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !edgeMode) |=> (irqOut == $past(polBit)));

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!evt && !pulseActive) |=> $stable(irqOut));

  p_level_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && evt && !edgeMode && polBit) |=> irqOut);

endmodule

bind pci_irq_router pirq_checker #(
  .LINE_W   (LINE_W),
  .LINE_BASE(LINE_BASE)
) i_pirqChk (
  .clk        (clk),
  .rstN       (rstN),
  .lineValid  (stat.lineValid),
  .lineNum    (lineNum),
  .evt        (stat.evt),
  .edgeMode   (stat.edgeMode),
  .polBit     (stat.polBit),
  .pinLevel   (pinLevel),
  .pulseActive(pulseActive),
  .irqOut     (irqOut)
);

// File: tb/test_pci_irq_router.sv
`timescale 1ns/1ps
module test_pci_irq_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  slotNum = '0;
  logic [1:0]  pinIdx = '0;
  logic        pinLevel = 1'b0;
  logic [31:0] edgeMask = '0;
  logic [31:0] polMask = '0;
  logic [5:0]  lineNum;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_irq_router i_pci_irq_router (
    .clk     (clk),
    .rstN    (rstN),
    .slotNum (slotNum),
    .pinIdx  (pinIdx),
    .pinLevel(pinLevel),
    .edgeMask(edgeMask),
    .polMask (polMask),
    .lineNum (lineNum),
    .irqOut  (irqOut)
  );

  // {slot[4:0], pin[1:0], expected line[5:0]}
  localparam logic [12:0] MAP_VEC [15] = '{
    {5'd5,  2'd0, 6'd32},  // R1
    {5'd5,  2'd3, 6'd35},  // R1
    {5'd6,  2'd0, 6'd36},  // R2
    {5'd6,  2'd2, 6'd36},  // R2
    {5'd7,  2'd1, 6'd37},  // R2
    {5'd7,  2'd3, 6'd37},  // R2
    {5'd8,  2'd0, 6'd38},  // R3
    {5'd8,  2'd3, 6'd41},  // R3
    {5'd10, 2'd1, 6'd41},  // R3
    {5'd12, 2'd0, 6'd42},  // R3
    {5'd12, 2'd3, 6'd45},  // R3
    {5'd0,  2'd2, 6'd2},   // R4
    {5'd4,  2'd1, 6'd1},   // R4
    {5'd13, 2'd3, 6'd3},   // R4
    {5'd31, 2'd0, 6'd0}    // R4
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int s, input int p, input bit lvl);
    @(negedge clk);
    slotNum  = 5'(s);
    pinIdx   = 2'(p);
    pinLevel = lvl;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    #1;
    check("R5 reset irqOut", irqOut, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // mapping table, level held low: no events
    for (int i = 0; i < 15; i++) begin
      drive(MAP_VEC[i][12:8], MAP_VEC[i][7:6], 1'b0);
      #1;
      check($sformatf("R1/R2/R3/R4 map vec %0d", i), lineNum, MAP_VEC[i][5:0]);
    end
    tick();
    check("R9 idle after table", irqOut, 0);

    // edge delivery on line 36 (index 4)
    @(negedge clk); edgeMask = 32'h1 << 4;
    drive(6, 0, 1'b1); tick();
    check("R6 pulse high", irqOut, 1);
    tick();
    check("R6 pulse one clock", irqOut, 0);
    tick();
    check("R7 steady high no pulse", irqOut, 0);
    drive(6, 0, 1'b0); tick();
    check("R7 falling no pulse", irqOut, 0);

    // level delivery on line 37 (index 5)
    @(negedge clk); polMask = 32'h1 << 5;
    drive(7, 2, 1'b1); tick();
    check("R8 level rise pol1", irqOut, 1);
    tick();
    check("R9 hold steady", irqOut, 1);
    @(negedge clk); polMask = '0;
    tick();
    check("R9 mask change no event", irqOut, 1);
    drive(7, 0, 1'b0); tick();
    check("R8 level fall pol0", irqOut, 0);
    @(negedge clk); polMask = 32'h1 << 5;
    drive(7, 1, 1'b1); tick();
    check("R8 level rise pol1 again", irqOut, 1);

    // unmapped slot has no effect
    drive(3, 1, 1'b0); tick();
    check("R4 unmapped low", irqOut, 1);
    drive(3, 1, 1'b1); tick();
    check("R4 unmapped rise", irqOut, 1);
    drive(3, 1, 1'b0); tick();
    check("R4 unmapped fall", irqOut, 1);

    // per-line level record
    drive(5, 0, 1'b1); tick();
    check("R11 line 32 event pol0", irqOut, 0);
    drive(7, 0, 1'b0); tick();
    check("R11 line 37 fall pol1", irqOut, 1);
    drive(5, 0, 1'b1); tick();
    check("R11 line 32 no repeat event", irqOut, 1);
    drive(7, 0, 1'b0); tick();
    check("R11 line 37 no repeat event", irqOut, 1);

    // pulse expiry coinciding with a level event
    drive(6, 0, 1'b1); tick();
    check("R6 pulse before collision", irqOut, 1);
    drive(7, 0, 1'b1); tick();
    check("R10 level wins at pulse end", irqOut, 1);
    tick();
    check("R10 holds after collision", irqOut, 1);

    // pulse ending with only unmapped activity
    drive(6, 0, 1'b0); tick();
    check("R7 edge fall holds", irqOut, 1);
    drive(6, 0, 1'b1); tick();
    check("R6 second pulse", irqOut, 1);
    drive(3, 0, 1'b0); tick();
    check("R6 pulse ends to 0", irqOut, 0);

    // reset in mid-run clears output and level records
    drive(7, 0, 1'b0); tick();
    check("R8 set high before reset", irqOut, 1);
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R5 async reset irqOut", irqOut, 0);
    @(negedge clk); rstN = 1'b1;
    drive(6, 0, 1'b1); tick();
    check("R5 record cleared gives rise", irqOut, 1);

    summary();
  end

endmodule